// File: doc/BRIEF.md
# Deferred Load Capture and Replay Buffer

This block sits beside a memory subsystem that can serve only one load at a time. While an earlier load is still waiting for a cache miss to resolve, later loads that reach the execute stage are taken out of the pipeline. Each one is stored as an effective address, a destination register number and a load opcode. The pipeline is told to turn that load into a nop, so independent instructions keep flowing. If there is no free entry, the block asks for a stall instead.

Once memory is free again, the stored loads go back to the memory stage one per cycle, oldest first. Each replay comes with a request to place a bubble in the execute stage. Read data can return for a load other than the one now in the memory stage. In that case the block asks for a memory-stage bubble and steers the data and its destination register towards the writeback registers.

The storage is circular, with DEPTH entries (8 by default). A read index and a write index track it, together with an occupancy count. Empty and full both come from that count.

Top module: `defer_load_buf`

## Requirements
- R1: After reset the buffer is empty. No replay is offered, and stall_o and ex_nop_o stay low.
- R2: A load is captured when all of these hold: a miss is pending, slack_i is non-zero, ex_valid_i and ex_is_load_i are high, and an entry is free. The capture raises ex_nop_o and keeps stall_o low.
- R3: An execute-stage instruction is not captured if slack_i is zero, if it is not a load, or if no miss is pending and the buffer is empty. ex_nop_o stays low and no replay appears later.
- R4: A capture request while all DEPTH entries are held and no replay happens that cycle raises stall_o. In that case ex_nop_o stays low and nothing is stored.
- R5: A replay (rp_valid_o high) is offered only while mem_free_i is high and the buffer holds an entry.
- R6: Replays come out in capture order, one per cycle, with address, register and opcode unchanged. Each replay raises ex_bubble_o.
- R7: A capture and a replay in the same cycle leave the occupancy unchanged. This holds when the buffer is full too: the new load is captured, not stalled.
- R8: Returning data flagged as belonging to another load (ret_valid_i and ret_foreign_i both high) raises mem_bubble_o and wb_we_o. It presents ret_data_i and ret_rd_i on wb_data_o and wb_rd_o. Otherwise wb_we_o is low.
- R9: While the buffer is not empty, a new load is captured even with no miss pending, so it cannot overtake older entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_pending_i | input | 1 | An earlier load is waiting on a miss |
| slack_i | input | SLACK_W | Remaining count of independent instructions |
| mem_free_i | input | 1 | Memory can accept a load this cycle |
| ex_valid_i | input | 1 | Execute stage holds a valid instruction |
| ex_is_load_i | input | 1 | Execute-stage instruction is a load |
| ex_addr_i | input | 32 | Effective address of the execute-stage load |
| ex_rd_i | input | 5 | Destination register |
| ex_op_i | input | 4 | Load opcode |
| ex_nop_o | output | 1 | Replace the execute-stage load with a nop |
| stall_o | output | 1 | Stall the pipeline: buffer full |
| ex_bubble_o | output | 1 | Insert a bubble in the execute stage for a replay |
| rp_valid_o | output | 1 | Replayed load presented to the memory stage |
| rp_addr_o | output | 32 | Replayed address |
| rp_rd_o | output | 5 | Replayed destination register |
| rp_op_o | output | 4 | Replayed opcode |
| ret_valid_i | input | 1 | Read data returning from memory |
| ret_foreign_i | input | 1 | Returning data belongs to a load not in the memory stage |
| ret_data_i | input | 32 | Returning data |
| ret_rd_i | input | 5 | Destination register of the returning data |
| mem_bubble_o | output | 1 | Insert a bubble in the memory stage |
| wb_we_o | output | 1 | Load the writeback registers from the return path |
| wb_data_o | output | 32 | Data towards writeback |
| wb_rd_o | output | 5 | Register towards writeback |

## Verification
The hardest case to reach is a capture landing in the same cycle as a replay while every entry is full. A write into the slot being read, or a stall raised by mistake, would both show up only there. The stimulus first fills the buffer under a held miss and proves that one more load stalls. It then frees memory while a further load sits in the execute stage. The following replays must show the original eight entries in order, followed by that late load and nothing more. This sequence also shows whether an entry is lost or issued twice.

// File: rtl/dlb_pkg.sv
package dlb_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned OP_W   = 4;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [REG_W-1:0]  rd;
    logic [OP_W-1:0]   op;
  } ld_entry_t;
endpackage

// File: rtl/dlb_ptr.sv
module dlb_ptr #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      // simultaneous push and pop keep the count
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign count_o  = cnt_q;
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/dlb_store.sv
module dlb_store
  import dlb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wr_ptr_i,
  input  ld_entry_t        wdata_i,
  input  logic [PTR_W-1:0] rd_ptr_i,
  output ld_entry_t        rdata_o
);
  ld_entry_t slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (we_i && (wr_ptr_i == PTR_W'(g))) slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[rd_ptr_i];
endmodule

// File: rtl/defer_load_buf.sv
module defer_load_buf
  import dlb_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned SLACK_W = 7,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_pending_i,
  input  logic [SLACK_W-1:0] slack_i,
  input  logic               mem_free_i,
  input  logic               ex_valid_i,
  input  logic               ex_is_load_i,
  input  logic [ADDR_W-1:0]  ex_addr_i,
  input  logic [REG_W-1:0]   ex_rd_i,
  input  logic [OP_W-1:0]    ex_op_i,
  output logic               ex_nop_o,
  output logic               stall_o,
  output logic               ex_bubble_o,
  output logic               rp_valid_o,
  output logic [ADDR_W-1:0]  rp_addr_o,
  output logic [REG_W-1:0]   rp_rd_o,
  output logic [OP_W-1:0]    rp_op_o,
  input  logic               ret_valid_i,
  input  logic               ret_foreign_i,
  input  logic [DATA_W-1:0]  ret_data_i,
  input  logic [REG_W-1:0]   ret_rd_i,
  output logic               mem_bubble_o,
  output logic               wb_we_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic [REG_W-1:0]   wb_rd_o
);
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             empty, full;
  logic             cand, push, pop;
  ld_entry_t        wentry, hentry;

  // a load is a candidate while memory is busy or older loads wait
  assign cand = ex_valid_i && ex_is_load_i && (slack_i != '0)
                && (miss_pending_i || !empty);
  assign pop  = !empty && mem_free_i;
  assign push = cand && (!full || pop);

  dlb_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .pop_i    (pop),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .count_o  (count),
    .empty_o  (empty),
    .full_o   (full)
  );

  assign wentry = '{addr: ex_addr_i, rd: ex_rd_i, op: ex_op_i};

  dlb_store #(.DEPTH(DEPTH)) u_store (
    .clk_i    (clk_i),
    .we_i     (push),
    .wr_ptr_i (wr_ptr),
    .wdata_i  (wentry),
    .rd_ptr_i (rd_ptr),
    .rdata_o  (hentry)
  );

  assign ex_nop_o    = push;
  assign stall_o     = cand && full && !pop;
  assign ex_bubble_o = pop;
  assign rp_valid_o  = pop;
  assign rp_addr_o   = hentry.addr;
  assign rp_rd_o     = hentry.rd;
  assign rp_op_o     = hentry.op;

  assign mem_bubble_o = ret_valid_i && ret_foreign_i;
  assign wb_we_o      = mem_bubble_o;
  assign wb_data_o    = ret_data_i;
  assign wb_rd_o      = ret_rd_i;
endmodule

// File: rtl/dlb_chk.sv
module dlb_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic [CNT_W-1:0] count_i,
  input logic             stall_i,
  input logic             nop_i,
  input logic             rp_valid_i,
  input logic             mem_free_i,
  input logic             ret_valid_i,
  input logic             wb_we_i
);
  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_i <= CNT_W'(DEPTH));
  assert_stall_no_nop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !nop_i);
  assert_replay_mem_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_valid_i |-> mem_free_i);
  assert_push_grows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> count_i == $past(count_i) + 1'b1);
  assert_swap_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(count_i));
  assert_wb_needs_ret_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_valid_i |-> !wb_we_i);
endmodule

bind defer_load_buf dlb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push),
  .pop_i       (pop),
  .count_i     (count),
  .stall_i     (stall_o),
  .nop_i       (ex_nop_o),
  .rp_valid_i  (rp_valid_o),
  .mem_free_i  (mem_free_i),
  .ret_valid_i (ret_valid_i),
  .wb_we_i     (wb_we_o)
);

// File: tb/sim_defer_load_buf.sv
`timescale 1ns/1ps
module sim_defer_load_buf;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_pending_i = 1'b0;
  logic [6:0]  slack_i = '0;
  logic        mem_free_i = 1'b0;
  logic        ex_valid_i = 1'b0, ex_is_load_i = 1'b0;
  logic [31:0] ex_addr_i = '0;
  logic [4:0]  ex_rd_i = '0;
  logic [3:0]  ex_op_i = '0;
  logic        ex_nop_o, stall_o, ex_bubble_o, rp_valid_o;
  logic [31:0] rp_addr_o;
  logic [4:0]  rp_rd_o;
  logic [3:0]  rp_op_o;
  logic        ret_valid_i = 1'b0, ret_foreign_i = 1'b0;
  logic [31:0] ret_data_i = '0;
  logic [4:0]  ret_rd_i = '0;
  logic        mem_bubble_o, wb_we_o;
  logic [31:0] wb_data_o;
  logic [4:0]  wb_rd_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  defer_load_buf u0 (.*);

  // capture vectors {addr, rd, op}; replay must return them unchanged, in order
  localparam logic [40:0] VEC [8] = '{
    {32'hA000_0040, 5'd1,  4'd2}, {32'hA000_1044, 5'd2,  4'd0},
    {32'h0000_0008, 5'd31, 4'd15},{32'hFFFF_FFFC, 5'd7,  4'd1},
    {32'h1234_5678, 5'd16, 4'd9}, {32'h8000_0000, 5'd0,  4'd3},
    {32'h0BAD_F00D, 5'd12, 4'd6}, {32'h5555_AAAA, 5'd21, 4'd12}
  };
  localparam logic [40:0] LATE  = {32'hC0DE_0100, 5'd9, 4'd5};
  localparam logic [40:0] DROP  = {32'hDEAD_0000, 5'd3, 4'd4};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_ld(input logic v, input logic [40:0] e);
    ex_valid_i = v; ex_is_load_i = v;
    {ex_addr_i, ex_rd_i, ex_op_i} = e;
  endtask

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    drive_ld(1'b1, DROP); slack_i = 7'd4;
    #1;
    chk("R1 rp_valid", rp_valid_o, 0);
    chk("R1 stall", stall_o, 0);
    chk("R1 nop", ex_nop_o, 0);
    tick(); rst_ni = 1'b1; tick();
    // R3: no miss, empty buffer: load passes through
    #1 chk("R3 no-miss nop", ex_nop_o, 0);
    tick();

    // R2: capture under miss, vector table walk
    miss_pending_i = 1'b1; mem_free_i = 1'b0; slack_i = 7'd5;
    for (int i = 0; i < 8; i++) begin
      drive_ld(1'b1, VEC[i]);
      #1;
      chk($sformatf("R2 nop v%0d", i), ex_nop_o, 1);
      chk($sformatf("R2 stall v%0d", i), stall_o, 0);
      chk($sformatf("R5 no replay v%0d", i), rp_valid_o, 0);
      tick();
    end
    // R4: full buffer stalls
    drive_ld(1'b1, DROP);
    #1;
    chk("R4 stall", stall_o, 1);
    chk("R4 nop", ex_nop_o, 0);
    tick(); tick();
    // R3: slack zero or non-load ignored
    slack_i = 7'd0; #1 chk("R3 slack0", ex_nop_o, 0);
    slack_i = 7'd3; ex_is_load_i = 1'b0; #1 chk("R3 nonload", ex_nop_o, 0);
    tick();

    // R7+R9: replay with a late load present while full, no miss
    miss_pending_i = 1'b0; mem_free_i = 1'b1;
    drive_ld(1'b1, LATE);
    #1;
    chk("R7 capture while full", ex_nop_o, 1);
    chk("R7 no stall", stall_o, 0);
    chk("R6 replay0", {rp_valid_o, ex_bubble_o, rp_addr_o, rp_rd_o, rp_op_o}, {2'b11, VEC[0]});
    tick();
    drive_ld(1'b0, DROP);
    for (int i = 1; i < 9; i++) begin
      #1;
      chk($sformatf("R6 replay%0d", i), {rp_valid_o, ex_bubble_o, rp_addr_o, rp_rd_o, rp_op_o},
          {2'b11, (i < 8) ? VEC[i] : LATE});
      tick();
    end
    #1 chk("R4 R9 drained", rp_valid_o, 0);
    tick();

    // R9: non-empty buffer captures without a miss
    miss_pending_i = 1'b1; mem_free_i = 1'b0;
    drive_ld(1'b1, VEC[3]); tick();
    miss_pending_i = 1'b0;
    drive_ld(1'b1, VEC[5]);
    #1 chk("R9 capture no miss", ex_nop_o, 1);
    tick(); drive_ld(1'b0, DROP); mem_free_i = 1'b1;
    #1 chk("R9 order a", {rp_valid_o, rp_addr_o}, {1'b1, VEC[3][40:9]});
    tick();
    #1 chk("R9 order b", {rp_valid_o, rp_addr_o}, {1'b1, VEC[5][40:9]});
    tick();
    #1 chk("R5 empty", rp_valid_o, 0);

    // R8: return path
    ret_valid_i = 1'b1; ret_foreign_i = 1'b1; ret_data_i = 32'hFEED_BEEF; ret_rd_i = 5'd17;
    #1 chk("R8 foreign", {mem_bubble_o, wb_we_o, wb_data_o, wb_rd_o}, {2'b11, 32'hFEED_BEEF, 5'd17});
    ret_foreign_i = 1'b0;
    #1 chk("R8 own", {mem_bubble_o, wb_we_o}, 2'b00);
    tick();
    ret_valid_i = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule